// File: doc/BRIEF.md
# Structured Conditional Lane-Mask Stack

This block tracks which lanes of a lockstep SIMT wave are active while the wave runs structured conditional code. The sequencer hands it each control instruction: an opcode (if, else, endif, or none) together with the per-lane predicate. The block keeps the active mask and a hardware stack of saved masks, one entry for each open conditional. At if, the lanes whose predicate is false are switched off. At else, the complementary lanes of the enclosing mask are switched on. At endif, the mask that held before the if comes back. The else clause may be left out.

When an if or an else leaves no lane active, the block raises a one-cycle skip flag, so the sequencer can jump over that body. The execution datapath asks for per-lane writes, and the block grants a write only to lanes that are active. A push onto a full stack and a pop from an empty stack are recorded in sticky error flags. Neither one changes the mask. A synchronous reset empties the stack and turns on every lane. The lane count and the stack depth are parameters.

Top module: `simt_cond_mask`

## Requirements
- R1: After reset, active_mask is all ones, skip, ovf_err and underflow_err are 0, and the stack is empty.
- R2: An accepted if (op=1, valid high, stack not full) pushes the current mask and its predicate. From the next cycle, active_mask equals the old mask AND pred.
- R3: An accepted else (op=2, stack not empty) sets active_mask to the mask saved by the innermost open if AND NOT that if's predicate. The stack is left unchanged.
- R4: An accepted endif (op=3, stack not empty) pops the innermost entry and restores its saved mask, whether or not an else came before it.
- R5: skip is high for exactly the cycle after an accepted if or else whose resulting active_mask is all zeros, and low in every other cycle.
- R6: lane_we equals lane_req AND active_mask in every cycle, so masked lanes never write.
- R7: Conditionals nest to DEPTH levels (DEPTH of at least 3). Each level uses one stack entry and unwinds in reverse order.
- R8: An if that arrives with DEPTH entries already held sets ovf_err. ovf_err stays set until reset. The mask and the stack do not change.
- R9: An else or endif on an empty stack sets underflow_err. underflow_err stays set until reset. The mask does not change.
- R10: A cycle with valid low, or with op=0, changes neither the mask nor the stack.
- R11: A synchronous reset in the middle of a run discards all open levels and clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | A control instruction is present this cycle |
| op | input | 2 | 0 none, 1 if, 2 else, 3 endif |
| pred | input | LANES | Per-lane condition for an if |
| lane_req | input | LANES | Per-lane write request from the datapath |
| active_mask | output | LANES | Current active-lane mask |
| lane_we | output | LANES | Per-lane write enable |
| skip | output | 1 | The body that just opened has no active lane |
| ovf_err | output | 1 | Sticky: push onto a full stack |
| underflow_err | output | 1 | Sticky: pop from an empty stack |

## Verification
On every cycle, the assertions check the following:
- An if only narrows the mask.
- An else stays inside the saved mask.
- An endif restores the top entry.
- skip never coincides with a live lane.
- Error cases leave the mask stable, and both error flags stay set.
- The stack count never leaves its range.

Some behaviours only the bench's scenarios can show:
- The exact lane values after an else at each nesting level.
- The last-in, first-out order when four levels unwind.
- A missing else.
- Clearing by reset part-way through a run.

A behavioural model, built on queues, follows the whole run cycle by cycle, including a long random opcode stream.

// File: rtl/simt_cm_pkg.sv
package simt_cm_pkg;
   typedef enum logic [1:0] {
      CM_NOP   = 2'd0,
      CM_IF    = 2'd1,
      CM_ELSE  = 2'd2,
      CM_ENDIF = 2'd3
   } cm_op_e;
endpackage

// File: rtl/cm_stack.sv
module cm_stack #(
   parameter int LANES           = 8,
   parameter int DEPTH           = 4,
   parameter bit STORE_ELSE_MASK = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic             pop,
   input  logic [LANES-1:0] push_saved,
   input  logic [LANES-1:0] push_pred,
   output logic [LANES-1:0] top_saved,
   output logic [LANES-1:0] top_else,
   output logic             full,
   output logic             empty
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [CW-1:0]    cnt_q;
   logic [LANES-1:0] sav_w [DEPTH];
   logic [LANES-1:0] aux_w [DEPTH];
   logic [IW-1:0]    top_idx;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (push && !full)  cnt_q <= cnt_q + 1'b1;
      else if (pop && !empty)  cnt_q <= cnt_q - 1'b1;
   end

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign top_idx = IW'(cnt_q - 1'b1);

   for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
      logic [LANES-1:0] sav_q;
      logic [LANES-1:0] aux_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            sav_q <= '0;
            aux_q <= '0;
         end else if (push && cnt_q == CW'(g)) begin
            sav_q <= push_saved;
            if (STORE_ELSE_MASK) aux_q <= push_saved & ~push_pred;
            else                 aux_q <= push_pred;
         end
      end
      assign sav_w[g] = sav_q;
      assign aux_w[g] = aux_q;
   end

   assign top_saved = empty ? '0 : sav_w[top_idx];

   if (STORE_ELSE_MASK) begin : g_pre_else
      assign top_else = empty ? '0 : aux_w[top_idx];
   end else begin : g_late_else
      assign top_else = empty ? '0 : (sav_w[top_idx] & ~aux_w[top_idx]);
   end

   // R7
   depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(DEPTH));
   // R8
   no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);
   // R9
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);
endmodule

// File: rtl/cm_next.sv
module cm_next
   import simt_cm_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic             valid,
   input  cm_op_e           op,
   input  logic [LANES-1:0] pred,
   input  logic [LANES-1:0] active,
   input  logic [LANES-1:0] top_saved,
   input  logic [LANES-1:0] top_else,
   input  logic             full,
   input  logic             empty,
   output logic             push,
   output logic             pop,
   output logic             upd,
   output logic [LANES-1:0] nxt_active,
   output logic             nxt_skip,
   output logic             set_ovf,
   output logic             set_udf
);
   always_comb begin
      push       = 1'b0;
      pop        = 1'b0;
      upd        = 1'b0;
      nxt_active = active;
      nxt_skip   = 1'b0;
      set_ovf    = 1'b0;
      set_udf    = 1'b0;
      if (valid) begin
         unique case (op)
            CM_IF: begin
               if (full) set_ovf = 1'b1;
               else begin
                  push       = 1'b1;
                  upd        = 1'b1;
                  nxt_active = active & pred;
                  nxt_skip   = ((active & pred) == '0);
               end
            end
            CM_ELSE: begin
               if (empty) set_udf = 1'b1;
               else begin
                  upd        = 1'b1;
                  nxt_active = top_else;
                  nxt_skip   = (top_else == '0);
               end
            end
            CM_ENDIF: begin
               if (empty) set_udf = 1'b1;
               else begin
                  pop        = 1'b1;
                  upd        = 1'b1;
                  nxt_active = top_saved;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cm_errs.sv
module cm_errs (
   input  logic clk,
   input  logic rst,
   input  logic set_ovf,
   input  logic set_udf,
   output logic ovf_q,
   output logic udf_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_q | set_ovf;
         udf_q <= udf_q | set_udf;
      end
   end

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_q |=> ovf_q);
   // R9
   udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      udf_q |=> udf_q);
endmodule

// File: rtl/simt_cond_mask.sv
module simt_cond_mask
   import simt_cm_pkg::*;
#(
   parameter int LANES           = 8,
   parameter int DEPTH           = 4,
   parameter bit STORE_ELSE_MASK = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid,
   input  logic [1:0]       op,
   input  logic [LANES-1:0] pred,
   input  logic [LANES-1:0] lane_req,
   output logic [LANES-1:0] active_mask,
   output logic [LANES-1:0] lane_we,
   output logic             skip,
   output logic             ovf_err,
   output logic             underflow_err
);
   initial begin
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (DEPTH >= 3) else $error("DEPTH must be at least 3");
   end

   cm_op_e           op_e;
   logic [LANES-1:0] active_q, nxt_active, top_saved, top_else;
   logic             skip_q, nxt_skip, upd, push, pop, full, empty;
   logic             set_ovf, set_udf;

   assign op_e = cm_op_e'(op);

   cm_stack #(.LANES(LANES), .DEPTH(DEPTH), .STORE_ELSE_MASK(STORE_ELSE_MASK)) u_stack (
      .clk(clk), .rst(rst), .push(push), .pop(pop),
      .push_saved(active_q), .push_pred(pred),
      .top_saved(top_saved), .top_else(top_else),
      .full(full), .empty(empty)
   );

   cm_next #(.LANES(LANES)) u_next (
      .valid(valid), .op(op_e), .pred(pred), .active(active_q),
      .top_saved(top_saved), .top_else(top_else),
      .full(full), .empty(empty),
      .push(push), .pop(pop), .upd(upd), .nxt_active(nxt_active),
      .nxt_skip(nxt_skip), .set_ovf(set_ovf), .set_udf(set_udf)
   );

   cm_errs u_errs (
      .clk(clk), .rst(rst), .set_ovf(set_ovf), .set_udf(set_udf),
      .ovf_q(ovf_err), .udf_q(underflow_err)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= '1;
         skip_q   <= 1'b0;
      end else begin
         if (upd) active_q <= nxt_active;
         skip_q <= nxt_skip;
      end
   end

   assign active_mask = active_q;
   assign skip        = skip_q;
   assign lane_we     = lane_req & active_q;

   // R2
   if_narrow_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && op_e == CM_IF && !full) |=> ((active_q & ~$past(active_q)) == '0));
   // R3
   else_inside_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && op_e == CM_ELSE && !empty) |=> ((active_q & ~$past(top_saved)) == '0));
   // R4
   endif_restore_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && op_e == CM_ENDIF && !empty) |=> (active_q == $past(top_saved)));
   // R5
   skip_dead_chk: assert property (@(posedge clk) disable iff (rst)
      skip_q |-> (active_q == '0));
   // R8
   ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && op_e == CM_IF && full) |=> (ovf_err && $stable(active_q)));
   // R9
   udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (valid && (op_e == CM_ELSE || op_e == CM_ENDIF) && empty) |=>
      (underflow_err && $stable(active_q)));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid || op_e == CM_NOP) |=> $stable(active_q));
endmodule

// File: tb/simt_cond_mask_tb.sv
module simt_cond_mask_tb;
   localparam int L = 8;
   localparam int D = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         valid = 1'b0;
   logic [1:0]   op = 2'd0;
   logic [L-1:0] pred = '0;
   logic [L-1:0] lane_req = '0;
   logic [L-1:0] active_mask, lane_we;
   logic         skip, ovf_err, underflow_err;

   int checks = 0;
   int fails  = 0;

   logic [L-1:0] m_active;
   logic         m_skip, m_ovf, m_udf;
   logic [L-1:0] q_saved[$];
   logic [L-1:0] q_pred[$];

   always #10 clk = ~clk;

   simt_cond_mask #(.LANES(L), .DEPTH(D)) u_dut (
      .clk(clk), .rst(rst), .valid(valid), .op(op), .pred(pred),
      .lane_req(lane_req), .active_mask(active_mask), .lane_we(lane_we),
      .skip(skip), .ovf_err(ovf_err), .underflow_err(underflow_err)
   );

   task automatic check(input string tag, input string what,
                        input logic [L-1:0] act, input logic [L-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model(input logic r, input logic v, input logic [1:0] o,
                        input logic [L-1:0] p);
      if (r) begin
         m_active = '1; m_skip = 0; m_ovf = 0; m_udf = 0;
         q_saved.delete(); q_pred.delete();
      end else begin
         m_skip = 0;
         if (v) begin
            case (o)
               2'd1: if (q_saved.size() == D) m_ovf = 1;
                     else begin
                        q_saved.push_back(m_active); q_pred.push_back(p);
                        m_active = m_active & p; m_skip = (m_active == '0);
                     end
               2'd2: if (q_saved.size() == 0) m_udf = 1;
                     else begin
                        m_active = q_saved[$] & ~q_pred[$];
                        m_skip = (m_active == '0);
                     end
               2'd3: if (q_saved.size() == 0) m_udf = 1;
                     else begin
                        m_active = q_saved.pop_back();
                        void'(q_pred.pop_back());
                     end
               default: ;
            endcase
         end
      end
   endtask

   task automatic cyc(input logic r, input logic v, input logic [1:0] o,
                      input logic [L-1:0] p, input logic [L-1:0] q, input string tag);
      rst = r; valid = v; op = o; pred = p; lane_req = q;
      @(posedge clk);
      model(r, v, o, p);
      @(negedge clk);
      check(tag, "active_mask", active_mask, m_active);
      check(tag, "skip", L'(skip), L'(m_skip));
      check(tag, "ovf_err", L'(ovf_err), L'(m_ovf));
      check(tag, "underflow_err", L'(underflow_err), L'(m_udf));
      check("R6", "lane_we", lane_we, q & m_active);
   endtask

   initial begin
      #(20 * 5000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc(1, 0, 0, '0, '0, "R1");
      cyc(1, 0, 0, '0, 8'hFF, "R1");
      // R2 R3 R4 basic divergence
      cyc(0, 1, 1, 8'hAA, 8'hFF, "R2");
      cyc(0, 1, 2, 8'h00, 8'hFF, "R3");
      cyc(0, 1, 3, 8'h00, 8'h0F, "R4");
      // R5 uniform true: else has no lanes
      cyc(0, 1, 1, 8'hFF, 8'hFF, "R5");
      cyc(0, 1, 2, 8'h00, 8'hFF, "R5");
      cyc(0, 0, 0, 8'h00, 8'hFF, "R5");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R4");
      // R5 uniform false: if body skipped
      cyc(0, 1, 1, 8'h00, 8'hF0, "R5");
      cyc(0, 1, 3, 8'h00, 8'hF0, "R4");
      // R4 no else
      cyc(0, 1, 1, 8'h3C, 8'hFF, "R2");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R4");
      // R10 idle cycles with noisy pred
      cyc(0, 1, 1, 8'h0F, 8'hFF, "R2");
      cyc(0, 0, 1, 8'h00, 8'h5A, "R10");
      cyc(0, 1, 0, 8'h00, 8'hA5, "R10");
      cyc(0, 0, 3, 8'hFF, 8'hFF, "R10");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R4");
      // R7 nesting to DEPTH, inner else, then R8 overflow
      cyc(0, 1, 1, 8'hFE, 8'hFF, "R7");
      cyc(0, 1, 1, 8'hF6, 8'hFF, "R7");
      cyc(0, 1, 2, 8'h00, 8'hFF, "R3");
      cyc(0, 1, 1, 8'h0C, 8'hFF, "R7");
      cyc(0, 1, 1, 8'h08, 8'hFF, "R7");
      cyc(0, 1, 1, 8'hFF, 8'hFF, "R8");
      cyc(0, 1, 2, 8'h00, 8'hFF, "R3");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R7");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R7");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R7");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R7");
      // R9 underflow
      cyc(0, 1, 3, 8'h00, 8'hFF, "R9");
      cyc(0, 1, 2, 8'h00, 8'hFF, "R9");
      cyc(0, 0, 0, 8'h00, 8'hFF, "R9");
      // R11 reset mid-run
      cyc(0, 1, 1, 8'h81, 8'hFF, "R11");
      cyc(0, 1, 1, 8'h01, 8'hFF, "R11");
      cyc(1, 1, 1, 8'h00, 8'hFF, "R11");
      cyc(0, 1, 3, 8'h00, 8'hFF, "R11");
      cyc(1, 0, 0, 8'h00, 8'hFF, "R11");
      // random stream against the model
      for (int i = 0; i < 600; i++) begin
         logic [1:0] o;
         string t;
         o = 2'($urandom % 4);
         case (o)
            2'd1: t = "R2";
            2'd2: t = "R3";
            2'd3: t = "R4";
            default: t = "R10";
         endcase
         cyc(($urandom % 97) == 0, ($urandom % 8) != 0, o,
             L'($urandom), L'($urandom), t);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule